// File: doc/BRIEF.md
# Configurable-Mode SPI Master

This block is a full-duplex serial peripheral master. The host places a word on `tx_data` and pulses `start`. The block then pulls one line of a small one-hot chip-select vector low and produces a serial clock. For each clock period it sends one bit on `mosi` and takes in one bit from `miso`. When the last bit has been exchanged, it releases the select line and pulses `done` for one cycle. The word it received is on `rx_data` in that same cycle.

Clock idle level (`cpol`), data phase (`cpha`) and bit order (`lsb_first`) are inputs. They are latched at each start, so every transfer can target a slave with a different mode. A read-only transfer (`rd_only`) still clocks a full word out, and that word is all ones. The parameter `DIV` sets the half period of the serial clock in system clock cycles, so the serial clock period is 2·DIV system cycles.

Top module: `spi_mode_master`

## Requirements
- R1: During and right after reset, every `cs_n` bit is 1, `sclk` is 0, and `done` and `busy` are 0.
- R2: While no transfer runs, `sclk` follows `cpol` (1 = idle high). After a transfer it rests at the polarity that the transfer latched.
- R3: A transfer makes exactly 2·W serial clock edges. Consecutive edges are DIV system cycles apart.
- R4: With `cpha`=0, the first bit is on `mosi` before the first edge. Both sides sample on odd-numbered edges (1st, 3rd, …). The next bit is driven on even-numbered edges.
- R5: With `cpha`=1, each bit is driven on an odd-numbered edge and sampled on the following even-numbered edge.
- R6: With `lsb_first`=1, bit 0 of the word is the first bit sent and received. With 0, bit W-1 goes first. The order applies in both directions.
- R7: With `rd_only`=1, the bits sent are all ones and `tx_data` is ignored. Received data is still captured.
- R8: During a transfer, only `cs_n[sel]` is 0. It stays steady from the start of the transfer to its end.
- R9: Select goes low at least DIV system cycles before the first edge. It goes high at least DIV cycles after the last edge.
- R10: `done` is high for exactly one cycle. In that cycle `rx_data` holds the received word. `busy` is 1 from the cycle after `start` until `done`.
- R11: A `start` pulse while `busy` is 1 is ignored. The running transfer continues unchanged and no extra transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Phase: 0 sample on odd edges, 1 on even edges |
| lsb_first | input | 1 | Bit order select |
| rd_only | input | 1 | Send all ones instead of `tx_data` |
| sel | input | SW | Index of the slave to select |
| tx_data | input | W | Word to send |
| rx_data | output | W | Word received by the last transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NSS | Active-low one-hot slave selects |

## Verification
A bench slave model follows the serial clock and the select lines. It records the bits it sees on `mosi` and returns a word of its own on `miso`. A wrong edge count or a stuck half-period counter shows in the same transfer, either as edge spacing other than DIV cycles or as a missing `done`. An off-by-one in the bit index or in phase handling corrupts the word in one direction or both, and that is seen at the `done` of that transfer. A select vector or polarity left in a wrong state shows on `cs_n` or `sclk` in the idle cycles right after `done`.

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int DIV = 4,
  parameter int W   = 8,
  parameter int NSS = 4,
  localparam int SW = (NSS > 1) ? $clog2(NSS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           cpol,
  input  logic           cpha,
  input  logic           lsb_first,
  input  logic           rd_only,
  input  logic [SW-1:0]  sel,
  input  logic [W-1:0]   tx_data,
  output logic [W-1:0]   rx_data,
  output logic           done,
  output logic           busy,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NSS-1:0] cs_n
);
  localparam int CW = $clog2(DIV) + 1;
  localparam int EW = $clog2(2 * W) + 1;
  localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

  typedef enum logic [1:0] {IDLE, XFER, HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [EW-1:0] edg;
  logic [W-1:0]  txsr, rxsr;
  logic          pol_q, pha_q, lsb_q;

  wire tick  = (cnt == '0);
  wire lead  = ~edg[0];
  wire samp  = pha_q ? ~lead : lead;
  wire shout = pha_q ? (lead && edg != '0) : (~lead && edg != LAST);

  assign busy = (st != IDLE);
  assign mosi = lsb_q ? txsr[0] : txsr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      edg     <= '0;
      txsr    <= '0;
      rxsr    <= '0;
      pol_q   <= 1'b0;
      pha_q   <= 1'b0;
      lsb_q   <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= '1;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: begin
          sclk <= cpol;
          if (start) begin
            pol_q <= cpol;
            pha_q <= cpha;
            lsb_q <= lsb_first;
            txsr  <= rd_only ? '1 : tx_data;
            cs_n  <= ~(NSS'(1) << sel);
            cnt   <= CW'(DIV - 1);
            edg   <= '0;
            st    <= XFER;
          end
        end
        XFER: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            cnt  <= CW'(DIV - 1);
            sclk <= ~sclk;
            edg  <= edg + 1'b1;
            if (samp)  rxsr <= lsb_q ? {miso, rxsr[W-1:1]} : {rxsr[W-2:0], miso};
            if (shout) txsr <= lsb_q ? (txsr >> 1) : (txsr << 1);
            if (edg == LAST) st <= HOLD;
          end
        end
        HOLD: begin
          if (!tick) cnt <= cnt - 1'b1;
          else begin
            cs_n    <= '1;
            done    <= 1'b1;
            rx_data <= rxsr;
            st      <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  p_cs_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cs_n));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sclk == pol_q));
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD) |=> $stable(sclk));
endmodule

// File: tb/spi_mode_master_tb.sv
module spi_mode_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4, W = 8, NSS = 4, SW = 2;

  logic clk = 0, rst_n = 0, start = 0, cpol = 0, cpha = 0, lsb_first = 0, rd_only = 0;
  logic [SW-1:0] sel = 0;
  logic [W-1:0] tx_data = 0, rx_data;
  logic done, busy, sclk, mosi, miso = 0;
  logic [NSS-1:0] cs_n;

  int n_run = 0, n_fail = 0, ndone = 0;
  bit finished = 0;

  spi_mode_master #(.DIV(DIV), .W(W), .NSS(NSS)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
    .lsb_first(lsb_first), .rd_only(rd_only), .sel(sel), .tx_data(tx_data),
    .rx_data(rx_data), .done(done), .busy(busy), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (done) ndone++;

  logic b_pha = 0, b_lsb = 0;
  logic [W-1:0] sbyte = 0, srx = 0;
  logic [NSS-1:0] cs_seen = '1;
  int edges = 0, si = 0;
  bit spacing_ok = 1;
  time tfall = 0, trise = 0, tfirst = 0, tlast = 0;
  wire act = ~&cs_n;

  function automatic int pos(input int i);
    return b_lsb ? i : W - 1 - i;
  endfunction

  always @(act) begin
    if (act) begin
      tfall = $time; edges = 0; si = 0; srx = '0; spacing_ok = 1; cs_seen = cs_n;
      if (!b_pha) begin #1 miso = sbyte[pos(0)]; end
    end else trise = $time;
  end

  always @(sclk) if (act) begin
    bit ld;
    edges++;
    if (edges == 1) tfirst = $time;
    else if ($time - tlast != DIV * CLK_PERIOD) spacing_ok = 0;
    tlast = $time;
    ld = edges[0];
    if (b_pha ? !ld : ld) begin
      if (si < W) srx[pos(si)] = mosi;
      si++;
    end
    if ((b_pha ? ld : !ld) && si < W) begin #1 miso = sbyte[pos(si)]; end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic xfer(input bit p, input bit h, input bit l, input bit r,
                      input logic [SW-1:0] s, input logic [W-1:0] tx,
                      input logic [W-1:0] sb, input bit poke);
    int guard = 0, d0;
    logic [W-1:0] exp_tx;
    @(negedge clk);
    cpol = p; cpha = h; lsb_first = l; rd_only = r; sel = s; tx_data = tx;
    b_pha = h; b_lsb = l; sbyte = sb;
    repeat (2) @(negedge clk);
    chk(sclk == p, "R2 idle level", sclk, p);
    d0 = ndone;
    start = 1; @(negedge clk); start = 0;
    chk(busy == 1, "R10 busy", busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      tx_data = ~tx; start = 1; @(negedge clk); start = 0;
    end
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    exp_tx = r ? '1 : tx;
    chk(done == 1, "R10 done seen", done, 1);
    chk(rx_data == sb, l ? "R6 rx order" : (h ? "R5 rx phase1" : "R4 rx phase0"), rx_data, sb);
    chk(srx == exp_tx, r ? "R7 fill" : (l ? "R6 tx order" : (h ? "R5 tx phase1" : "R4 tx phase0")), srx, exp_tx);
    chk(edges == 2 * W, "R3 edge count", edges, 2 * W);
    chk(spacing_ok, "R3 edge spacing", spacing_ok, 1);
    chk(cs_seen == ~(NSS'(1) << s), "R8 select", cs_seen, ~(NSS'(1) << s));
    chk((tfirst - tfall) >= DIV * CLK_PERIOD, "R9 setup", int'(tfirst - tfall), DIV * CLK_PERIOD);
    chk((trise - tlast) >= DIV * CLK_PERIOD, "R9 hold", int'(trise - tlast), DIV * CLK_PERIOD);
    @(negedge clk);
    chk(done == 0, "R10 pulse width", done, 0);
    chk(sclk == p && cs_n == '1, "R2 rest level", {cs_n, sclk}, {4'hF, p});
    if (poke) begin
      repeat (3 * DIV) @(negedge clk);
      chk(ndone - d0 == 1 && !busy, "R11 start ignored", ndone - d0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    #(CLK_PERIOD * 3 + 2);
    chk(cs_n == '1 && sclk == 0 && !done && !busy, "R1 reset", {cs_n, sclk, done, busy}, 7'h78);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == '1 && !busy, "R1 after release", {cs_n, busy}, 5'h1E);
    for (int m = 0; m < 8; m++)
      xfer(m[0], m[1], m[2], 0, SW'(m), 8'hA5 ^ 8'(m), 8'h3C + 8'(m), 0);
    xfer(0, 0, 0, 1, 2'd1, 8'h00, 8'h96, 0);
    xfer(1, 1, 1, 1, 2'd3, 8'h12, 8'h01, 0);
    xfer(0, 1, 0, 0, 2'd2, 8'h80, 8'hFE, 1);
    xfer(1, 0, 1, 0, 2'd0, 8'h00, 8'hFF, 0);
    for (int i = 0; i < 24; i++) begin
      int unsigned rv = $urandom;
      xfer(rv[0], rv[1], rv[2], rv[3], SW'(rv[5:4]), W'($urandom), W'($urandom), rv[6] & rv[7]);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule